// File: doc/BRIEF.md
# Address-Triggered Load/Store Register Unit

This block holds the register state of a machine with three register classes: eight wide data registers, eight address registers and eight index registers. No arithmetic instruction names memory. Memory traffic happens only as a side effect: when an instruction writes an address register, the unit starts a transfer between the data register with the same number and the new address. Writing address registers 1 to 5 loads the matching data register. Writing registers 6 and 7 stores the matching data register. Writing register 0 only updates the register.

The unit takes one instruction word per accepted cycle through a valid/ready pair. It decodes two formats. The short format names three registers and does data arithmetic. The long format carries an 18-bit displacement and does address and index arithmetic. The unit keeps at most one memory transfer outstanding on a request/acknowledge port. It holds back an instruction that touches a data register still waiting for its load. An instruction that does not depend on the outstanding load goes ahead at once. An index zero-test instruction drives a condition output, which an outside sequencer uses to end a counted vector loop. A read-only observation port selects any register for inspection.

Top module: `lsu_regunit`

## Requirements
- R1: After reset, every register reads zero, `mem_req` and `cond_zero` are 0, and `inst_ready` is 1 when no instruction is offered.
- R2: Instruction fields: opcode in bits [29:24], i in [23:21], j in [20:18], k in [17:15], and a displacement in [17:0] for the long format. The short opcodes 1/2/3/4/5 set Xi to Xj+Xk, Xj−Xk, Xj AND Xk, Xj OR Xk and Xj XOR Xk, each modulo 2^60. Unlisted opcodes do nothing.
- R3: Long opcode 8 sets Ai = Bj + disp. Opcode 9 sets Ai = Aj + disp. Opcode 12 sets Bi = Bj + disp. All address and index sums wrap modulo 2^18.
- R4: Writing Ai with i in 1..5 issues a read (`mem_we`=0) at the new Ai. When it is acknowledged, Xi takes `mem_rdata`.
- R5: Writing A6 or A7 issues a write (`mem_we`=1) at the new address. The write data is X6 or X7 as it stood when the instruction was accepted.
- R6: Writing A0 updates A0 and issues no memory request.
- R7: B0 always reads zero, and writes to it are ignored.
- R8: While a load into Xn is outstanding, an instruction that reads or writes Xn is held (`inst_ready`=0) until the load returns, and then it uses the loaded value. Data instructions that do not touch Xn are accepted without delay.
- R9: Only one transfer is outstanding at a time. A second address write that would trigger memory is held until the first is acknowledged. Request address, direction and data stay stable until acknowledged.
- R10: Opcode 14 sets `cond_zero` to (Bj == 0) from the cycle after acceptance. It holds that value until the next such instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inst_valid | input | 1 | Instruction word offered |
| inst_word | input | 30 | Instruction word |
| inst_ready | output | 1 | Instruction accepted this cycle if valid |
| cond_zero | output | 1 | Result of the last index zero test |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 18 | Request word address |
| mem_wdata | output | 60 | Store data |
| mem_ack | input | 1 | Memory completes the pending request |
| mem_rdata | input | 60 | Load data, valid with mem_ack |
| obs_class | input | 2 | Register class to observe: 0 data, 1 address, 2 index |
| obs_idx | input | 3 | Register number to observe |
| obs_data | output | 60 | Observed register, zero-extended |

## Verification
The assertions check every cycle that a request keeps its address, direction and data until acknowledged. They also check that the request direction matches the pairing of the triggering register, that no request ever comes from address register 0, that no accepted data instruction overlaps a pending load target, and that B0 stays zero after a write. Only the bench scenarios can show the values themselves. These are the arithmetic results, wrapped addresses, the data actually loaded and stored, stall lengths against memory latency, and a complete counted vector-add loop driven by the zero test.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int XW       = 60;
  localparam int AW       = 18;
  localparam int NREG     = 8;
  localparam int RIW      = $clog2(NREG);
  localparam int OPW      = 6;
  localparam int DW       = AW;
  localparam int IW       = OPW + 2 * RIW + DW;
  localparam int FIRST_ST = 6;

  localparam logic [OPW-1:0] OP_XADD   = 6'd1;
  localparam logic [OPW-1:0] OP_XSUB   = 6'd2;
  localparam logic [OPW-1:0] OP_XAND   = 6'd3;
  localparam logic [OPW-1:0] OP_XIOR   = 6'd4;
  localparam logic [OPW-1:0] OP_XXOR   = 6'd5;
  localparam logic [OPW-1:0] OP_ASETB  = 6'd8;
  localparam logic [OPW-1:0] OP_ASETA  = 6'd9;
  localparam logic [OPW-1:0] OP_BSET   = 6'd12;
  localparam logic [OPW-1:0] OP_BZTEST = 6'd14;

  typedef enum logic [1:0] {CL_X = 2'd0, CL_A = 2'd1, CL_B = 2'd2} rclass_e;

  typedef struct packed {
    logic [OPW-1:0] op;
    logic           x_wr;
    logic           a_wr;
    logic           b_wr;
    logic           ztest;
    logic           a_base_a;
    logic           rd_xj;
    logic           rd_xk;
    logic [RIW-1:0] i;
    logic [RIW-1:0] j;
    logic [RIW-1:0] k;
    logic [DW-1:0]  disp;
  } dec_t;

  function automatic logic [XW-1:0] x_alu(input logic [OPW-1:0] op,
                                          input logic [XW-1:0] a,
                                          input logic [XW-1:0] b);
    logic [XW-1:0] r;
    case (op)
      OP_XADD: r = a + b;
      OP_XSUB: r = a - b;
      OP_XAND: r = a & b;
      OP_XIOR: r = a | b;
      OP_XXOR: r = a ^ b;
      default: r = a;
    endcase
    return r;
  endfunction

  function automatic logic [AW-1:0] addr_add(input logic [AW-1:0] base,
                                             input logic [DW-1:0] disp);
    return base + disp;
  endfunction

  function automatic logic slot_has_mem(input logic [RIW-1:0] idx);
    return idx != '0;
  endfunction

  function automatic logic slot_is_store(input logic [RIW-1:0] idx);
    return int'(idx) >= FIRST_ST;
  endfunction
endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
(
  input  logic [IW-1:0] inst,
  output dec_t          dec
);
  always_comb begin
    dec      = '0;
    dec.op   = inst[IW-1 -: OPW];
    dec.i    = inst[IW-OPW-1 -: RIW];
    dec.j    = inst[IW-OPW-RIW-1 -: RIW];
    dec.k    = inst[DW-1 -: RIW];
    dec.disp = inst[DW-1:0];
    case (dec.op)
      OP_XADD, OP_XSUB, OP_XAND, OP_XIOR, OP_XXOR: begin
        dec.x_wr  = 1'b1;
        dec.rd_xj = 1'b1;
        dec.rd_xk = 1'b1;
      end
      OP_ASETB:  dec.a_wr = 1'b1;
      OP_ASETA: begin
        dec.a_wr     = 1'b1;
        dec.a_base_a = 1'b1;
      end
      OP_BSET:   dec.b_wr  = 1'b1;
      OP_BZTEST: dec.ztest = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/lsu_regfile.sv
module lsu_regfile #(
  parameter int W     = 60,
  parameter int N     = 8,
  parameter int NWP   = 1,
  parameter bit ZERO0 = 1'b0,
  parameter int AWI   = $clog2(N)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NWP-1:0]           we,
  input  logic [NWP-1:0][AWI-1:0]  wa,
  input  logic [NWP-1:0][W-1:0]    wd,
  output logic [N-1:0][W-1:0]      q
);
  for (genvar r = 0; r < N; r++) begin : g_reg
    if (ZERO0 && r == 0) begin : g_zero
      assign q[r] = '0;
    end else begin : g_store
      logic         hit;
      logic [W-1:0] nxt;
      logic [W-1:0] val;
      always_comb begin
        hit = 1'b0;
        nxt = val;
        for (int p = 0; p < NWP; p++) begin
          if (we[p] && wa[p] == AWI'(r)) begin
            hit = 1'b1;
            nxt = wd[p];
          end
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   val <= '0;
        else if (hit) val <= nxt;
      end
      assign q[r] = val;
    end
  end
endmodule

// File: rtl/lsu_memseq.sv
module lsu_memseq
  import lsu_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [RIW-1:0] st_idx,
  input  logic [AW-1:0]  st_addr,
  input  logic [XW-1:0]  st_wdata,
  input  logic           mem_ack,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [XW-1:0]  mem_wdata,
  output logic           busy,
  output logic           pend_load,
  output logic [RIW-1:0] pend_idx,
  output logic           ld_done
);
  logic           req_q, we_q;
  logic [AW-1:0]  addr_q;
  logic [XW-1:0]  wdata_q;
  logic [RIW-1:0] idx_q;
  logic           ack_hit;

  assign ack_hit = req_q && mem_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      idx_q   <= '0;
    end else if (start) begin
      req_q   <= 1'b1;
      we_q    <= slot_is_store(st_idx);
      addr_q  <= st_addr;
      wdata_q <= st_wdata;
      idx_q   <= st_idx;
    end else if (ack_hit) begin
      req_q   <= 1'b0;
    end
  end

  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign busy      = req_q;
  assign pend_load = req_q && !we_q;
  assign pend_idx  = idx_q;
  assign ld_done   = ack_hit && !we_q;

  // R9: request fields hold until acknowledged
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R4/R5: direction follows the pairing of the triggering register
  a_r5_dir_pairing: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_we == (int'(pend_idx) >= FIRST_ST)));

  // R6: register slot 0 never owns a request
  a_r6_no_slot0_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (pend_idx != '0));
endmodule

// File: rtl/lsu_regunit.sv
module lsu_regunit
  import lsu_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           inst_valid,
  input  logic [IW-1:0]  inst_word,
  output logic           inst_ready,
  output logic           cond_zero,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [XW-1:0]  mem_wdata,
  input  logic           mem_ack,
  input  logic [XW-1:0]  mem_rdata,
  input  logic [1:0]     obs_class,
  input  logic [RIW-1:0] obs_idx,
  output logic [XW-1:0]  obs_data
);
  dec_t d;
  logic [NREG-1:0][XW-1:0] x_q;
  logic [NREG-1:0][AW-1:0] a_q;
  logic [NREG-1:0][AW-1:0] b_q;

  logic           busy, pend_load, ld_done;
  logic [RIW-1:0] pend_idx;
  logic           haz_x, haz_mem, mem_trig, accept;
  logic [AW-1:0]  new_addr, new_index;
  logic [XW-1:0]  alu_res;
  logic           cond_q;

  lsu_decode u_dec (.inst(inst_word), .dec(d));

  // hazard events, named for the checks below
  assign mem_trig = d.a_wr && slot_has_mem(d.i);
  assign haz_x    = pend_load && ((d.rd_xj && d.j == pend_idx) ||
                                  (d.rd_xk && d.k == pend_idx) ||
                                  (d.x_wr  && d.i == pend_idx));
  assign haz_mem  = mem_trig && busy;
  assign inst_ready = !(haz_x || haz_mem);
  assign accept     = inst_valid && inst_ready;

  assign new_addr  = addr_add(d.a_base_a ? a_q[d.j] : b_q[d.j], d.disp);
  assign new_index = addr_add(b_q[d.j], d.disp);
  assign alu_res   = x_alu(d.op, x_q[d.j], x_q[d.k]);

  lsu_regfile #(.W(XW), .N(NREG), .NWP(2), .ZERO0(1'b0)) u_xrf (
    .clk(clk), .rst_n(rst_n),
    .we({ld_done, accept && d.x_wr}),
    .wa({pend_idx, d.i}),
    .wd({mem_rdata, alu_res}),
    .q(x_q)
  );

  lsu_regfile #(.W(AW), .N(NREG), .NWP(1), .ZERO0(1'b0)) u_arf (
    .clk(clk), .rst_n(rst_n),
    .we(accept && d.a_wr),
    .wa(d.i),
    .wd(new_addr),
    .q(a_q)
  );

  lsu_regfile #(.W(AW), .N(NREG), .NWP(1), .ZERO0(1'b1)) u_brf (
    .clk(clk), .rst_n(rst_n),
    .we(accept && d.b_wr),
    .wa(d.i),
    .wd(new_index),
    .q(b_q)
  );

  lsu_memseq u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(accept && mem_trig),
    .st_idx(d.i),
    .st_addr(new_addr),
    .st_wdata(x_q[d.i]),
    .mem_ack(mem_ack),
    .mem_req(mem_req),
    .mem_we(mem_we),
    .mem_addr(mem_addr),
    .mem_wdata(mem_wdata),
    .busy(busy),
    .pend_load(pend_load),
    .pend_idx(pend_idx),
    .ld_done(ld_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cond_q <= 1'b0;
    else if (accept && d.ztest)  cond_q <= (b_q[d.j] == '0);
  end
  assign cond_zero = cond_q;

  always_comb begin
    case (rclass_e'(obs_class))
      CL_X:    obs_data = x_q[obs_idx];
      CL_A:    obs_data = XW'(a_q[obs_idx]);
      CL_B:    obs_data = XW'(b_q[obs_idx]);
      default: obs_data = '0;
    endcase
  end

  // R8: an accepted data instruction never writes the pending load target
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && d.x_wr && pend_load) |-> (d.i != pend_idx));

  // R7: a write aimed at B0 leaves it reading zero
  a_r7_b0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && d.b_wr && d.i == '0) |=> (b_q[0] == '0));

  // R6: an A0 write with no transfer in flight starts none
  a_r6_a0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && d.a_wr && d.i == '0 && !mem_req) |=> !mem_req);
endmodule

// File: tb/lsu_regunit_bench.sv
module lsu_regunit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inst_valid = 1'b0;
  logic [29:0] inst_word = '0;
  logic        inst_ready, cond_zero, mem_req, mem_we;
  logic [17:0] mem_addr;
  logic [59:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [59:0] mem_rdata = '0;
  logic [1:0]  obs_class = '0;
  logic [2:0]  obs_idx = '0;
  logic [59:0] obs_data;

  int total = 0, bad = 0;
  int lat = 1, wait_cnt = 0;
  int st_cnt = 0, ld_cnt = 0, req_cnt = 0;
  logic prev_req = 1'b0;
  logic [17:0] last_st_addr = '0;
  logic [59:0] last_st_data = '0;
  logic [59:0] xs [8];

  always #5 clk = ~clk;

  lsu_regunit u_lsu_regunit (
    .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .inst_word(inst_word),
    .inst_ready(inst_ready), .cond_zero(cond_zero), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .obs_class(obs_class),
    .obs_idx(obs_idx), .obs_data(obs_data)
  );

  function automatic logic [59:0] ld_val(input logic [17:0] a);
    return {6'h2A, a, ~a, a};
  endfunction

  function automatic logic [59:0] model(input logic [5:0] op, input logic [59:0] a, b);
    if (op == 6'd1) return a + b;
    if (op == 6'd2) return a - b;
    if (op == 6'd3) return a & b;
    if (op == 6'd4) return a | b;
    return a ^ b;
  endfunction

  function automatic logic [29:0] enc_s(input logic [5:0] op, input logic [2:0] i, j, k);
    return {op, i, j, k, 15'd0};
  endfunction

  function automatic logic [29:0] enc_l(input logic [5:0] op, input logic [2:0] i, j,
                                        input logic [17:0] disp);
    return {op, i, j, disp};
  endfunction

  // memory model: acknowledges after lat waiting cycles
  initial begin
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (mem_req && !prev_req) req_cnt++;
      if (mem_req && wait_cnt >= lat && !(prev_req && mem_ack)) begin
        mem_ack   = 1'b1;
        mem_rdata = ld_val(mem_addr);
        if (mem_we) begin
          st_cnt++;
          last_st_addr = mem_addr;
          last_st_data = mem_wdata;
        end else ld_cnt++;
        wait_cnt = 0;
      end else if (mem_req) wait_cnt++;
      prev_req = mem_req;
    end
  end

  task automatic chk(input string tag, input logic [59:0] act, input logic [59:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [29:0] w, output int st);
    st = 0;
    @(negedge clk);
    inst_word = w;
    inst_valid = 1'b1;
    #1;
    while (!inst_ready) begin
      @(negedge clk);
      #1;
      st++;
    end
    @(posedge clk);
    #1;
    inst_valid = 1'b0;
    inst_word = '0;
  endtask

  task automatic run(input logic [29:0] w);
    int st;
    issue(w, st);
  endtask

  task automatic idle();
    @(negedge clk);
    while (mem_req) @(negedge clk);
    #1;
  endtask

  task automatic peek(input logic [1:0] c, input logic [2:0] n, output logic [59:0] v);
    obs_class = c;
    obs_idx = n;
    #1;
    v = obs_data;
  endtask

  // op, i, j, k
  localparam logic [14:0] TBL [8] = '{
    {6'd1, 3'd3, 3'd1, 3'd2},
    {6'd2, 3'd4, 3'd1, 3'd2},
    {6'd2, 3'd5, 3'd2, 3'd1},
    {6'd3, 3'd6, 3'd1, 3'd2},
    {6'd4, 3'd7, 3'd1, 3'd2},
    {6'd5, 3'd3, 3'd3, 3'd4},
    {6'd1, 3'd4, 3'd4, 3'd4},
    {6'd5, 3'd5, 3'd5, 3'd5}
  };

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none
  end

  initial begin
    logic [59:0] v, w;
    int st, r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    for (int c = 0; c < 3; c++)
      for (int n = 0; n < 8; n++) begin
        peek(c[1:0], n[2:0], v);
        chk($sformatf("R1 reg c%0d n%0d", c, n), v, 60'd0);
      end
    chk("R1 mem_req", {59'd0, mem_req}, 60'd0);
    chk("R1 ready", {59'd0, inst_ready}, 60'd1);
    chk("R1 cond", {59'd0, cond_zero}, 60'd0);

    // R3/R4 setup: B2=100, A1=B2+16 loads X1, A2=B2+5 loads X2
    run(enc_l(6'd12, 3'd2, 3'd0, 18'd100));
    run(enc_l(6'd8, 3'd1, 3'd2, 18'd16));
    chk("R4 request is read", {59'd0, mem_we}, 60'd0);
    chk("R4 request addr", {42'd0, mem_addr}, 60'd116);
    idle();
    peek(2'd1, 3'd1, v); chk("R3 A1=B2+disp", v, 60'd116);
    peek(2'd0, 3'd1, v); chk("R4 X1 loaded", v, ld_val(18'd116));
    run(enc_l(6'd8, 3'd2, 3'd2, 18'd5));
    idle();
    peek(2'd0, 3'd2, v); chk("R4 X2 loaded", v, ld_val(18'd105));
    xs[1] = ld_val(18'd116);
    xs[2] = ld_val(18'd105);
    for (int n = 3; n < 8; n++) xs[n] = '0;

    // R2 table of data operations
    for (int t = 0; t < 8; t++) begin
      logic [5:0] op;
      logic [2:0] i, j, k;
      {op, i, j, k} = TBL[t];
      issue(enc_s(op, i, j, k), st);
      chk($sformatf("R8 no stall entry %0d", t), 60'(st), 60'd0);
      xs[i] = model(op, xs[j], xs[k]);
      peek(2'd0, i, v);
      chk($sformatf("R2 table entry %0d", t), v, xs[i]);
    end
    run({6'd7, 24'hABCDEF});
    peek(2'd0, 3'd3, v); chk("R2 unlisted opcode no effect", v, xs[3]);

    // R5 stores of X6 and X7
    run(enc_l(6'd8, 3'd6, 3'd2, 18'd40));
    idle();
    chk("R5 store addr A6", {42'd0, last_st_addr}, 60'd140);
    chk("R5 store data X6", last_st_data, xs[6]);
    run(enc_l(6'd8, 3'd7, 3'd2, 18'd3));
    idle();
    chk("R5 store data X7", last_st_data, xs[7]);
    chk("R5 store count", 60'(st_cnt), 60'd2);

    // R6 A0 write: no request
    r0 = req_cnt;
    run(enc_l(6'd8, 3'd0, 3'd2, 18'd1));
    repeat (5) @(negedge clk);
    chk("R6 no request from A0", 60'(req_cnt), 60'(r0));
    peek(2'd1, 3'd0, v); chk("R6 A0 value", v, 60'd101);

    // R7 B0 constant zero
    run(enc_l(6'd12, 3'd0, 3'd2, 18'd7));
    peek(2'd2, 3'd0, v); chk("R7 B0 ignores write", v, 60'd0);
    run(enc_l(6'd8, 3'd3, 3'd0, 18'd9));
    idle();
    peek(2'd1, 3'd3, v); chk("R7 A3 from B0", v, 60'd9);
    peek(2'd0, 3'd3, v); chk("R7 X3 loaded", v, ld_val(18'd9));
    xs[3] = ld_val(18'd9);

    // R3 wrap-around
    run(enc_l(6'd12, 3'd3, 3'd2, 18'h3FFFF));
    peek(2'd2, 3'd3, v); chk("R3 index wrap", v, 60'd99);
    run(enc_l(6'd9, 3'd5, 3'd1, 18'h3FFF0));
    idle();
    peek(2'd1, 3'd5, v); chk("R3 address wrap", v, 60'd100);
    peek(2'd0, 3'd5, v); chk("R4 X5 from wrapped addr", v, ld_val(18'd100));
    xs[5] = ld_val(18'd100);

    // R8 load-use hazard with slow memory
    lat = 5;
    run(enc_l(6'd8, 3'd1, 3'd2, 18'd32));
    issue(enc_s(6'd1, 3'd4, 3'd2, 3'd3), st);
    chk("R8 independent op not held", 60'(st), 60'd0);
    xs[4] = xs[2] + xs[3];
    issue(enc_s(6'd1, 3'd3, 3'd1, 3'd2), st);
    chk("R8 dependent op held", 60'(st > 0), 60'd1);
    xs[1] = ld_val(18'd132);
    xs[3] = xs[1] + xs[2];
    peek(2'd0, 3'd3, v); chk("R8 uses loaded value", v, xs[3]);
    peek(2'd0, 3'd4, v); chk("R8 independent result", v, xs[4]);

    // R9 second trigger held while one is outstanding
    r0 = ld_cnt;
    run(enc_l(6'd8, 3'd2, 3'd2, 18'd50));
    issue(enc_l(6'd8, 3'd4, 3'd2, 18'd60), st);
    chk("R9 second trigger held", 60'(st > 0), 60'd1);
    chk("R9 second addr", {42'd0, mem_addr}, 60'd160);
    idle();
    chk("R9 both loads done", 60'(ld_cnt - r0), 60'd2);
    peek(2'd0, 3'd2, v); chk("R9 X2", v, ld_val(18'd150));
    peek(2'd0, 3'd4, v); chk("R9 X4", v, ld_val(18'd160));
    lat = 1;

    // R10 counted vector-add loop, B1 counts down to zero
    run(enc_l(6'd12, 3'd1, 3'd0, 18'd2));
    for (int it = 0; it < 2; it++) begin
      logic [17:0] b1;
      b1 = 18'(2 - it);
      run(enc_l(6'd14, 3'd0, 3'd1, 18'd0));
      chk($sformatf("R10 not zero iter %0d", it), {59'd0, cond_zero}, 60'd0);
      run(enc_l(6'd8, 3'd1, 3'd1, 18'd200));
      run(enc_l(6'd8, 3'd2, 3'd1, 18'd300));
      run(enc_s(6'd1, 3'd6, 3'd1, 3'd2));
      run(enc_l(6'd8, 3'd6, 3'd1, 18'd400));
      idle();
      w = ld_val(b1 + 18'd200) + ld_val(b1 + 18'd300);
      chk($sformatf("R5 loop store addr %0d", it), {42'd0, last_st_addr}, 60'(b1 + 18'd400));
      chk($sformatf("R5 loop store data %0d", it), last_st_data, w);
      run(enc_l(6'd12, 3'd1, 3'd1, 18'h3FFFF));
    end
    run(enc_l(6'd14, 3'd0, 3'd1, 18'd0));
    chk("R10 zero at loop end", {59'd0, cond_zero}, 60'd1);
    repeat (3) @(negedge clk);
    chk("R10 holds value", {59'd0, cond_zero}, 60'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule